// File: doc/BRIEF.md
# Instruction Line Realignment Buffer

This block sits between a 128-bit instruction fetch port and the issue stage. Each fetched quad-word carries four 32-bit instruction slots. Instruction lines are one to four instructions long and may start at any slot. A line ends at the first slot whose end-of-line flag is set. The buffer queues fetched slots in a ring of five quad-words (twenty slots). Each cycle it presents the oldest complete instruction line, repacked so that its first instruction is in output slot 0, together with a per-slot valid mask. Because lines are rebuilt across quad-word boundaries, code in memory needs no alignment padding.

The fetch side uses a valid/ready pair. A slot offset on the fetch input drops the leading slots of a quad-word, which lets a branch target start in the middle of a quad-word. The issue side is not stalled: a complete line is consumed in the cycle it is shown. A flush input, raised on a branch redirect, empties the buffer in one cycle.

A small controller tracks occupancy in three named states. `S_IDLE` means the buffer is empty. `S_FILL` means it holds slots and has room for a full quad-word. `S_FULL` means it holds more than sixteen slots, so it has no room for another quad-word. The transitions are: IDLE→FILL when slots arrive; FILL→FULL when occupancy passes sixteen slots; FULL→FILL when issue drains it back to sixteen or fewer; FILL→IDLE and FULL→IDLE on flush or when the last slot is issued. Each state stays put otherwise.

Top module: `iab_align_top`

## Requirements
- R1: After reset, `line_valid` is 0 and `fetch_ready` is 1.
- R2: When `flush` is low, `fetch_ready` is high exactly when the buffer holds at most 16 slots, so that four free slots remain. A quad-word is taken on a cycle with `fetch_valid` and `fetch_ready` both high.
- R3: A quad-word taken with `fetch_offset` = o appends its slots o..3 in ascending slot order. Slot i occupies `fetch_data[32*i+31:32*i]`. Slots below o are discarded.
- R4: A line ends at the first buffered slot with bit 31 set. The line of length n has its instructions in output slots 0..n-1, `line_mask` = 2^n−1, and all other bits of `line_data` are zero.
- R5: A line is not presented until all of its slots are buffered. Slots written by a taken quad-word become visible on the next cycle. One line is consumed in every cycle that `line_valid` is high.
- R6: If the four oldest buffered slots contain no end-of-line flag, they are issued as one four-instruction line.
- R7: While `flush` is high, `line_valid` and `fetch_ready` are both 0 and the fetch input is ignored. From the next cycle the buffer is empty.
- R8: Slot order is preserved across quad-word boundaries, so a line that straddles two quad-words is rebuilt in its original order.
- R9: The buffer never holds more than 20 slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Discard all buffered slots (branch redirect) |
| fetch_valid | input | 1 | Fetch quad-word present |
| fetch_offset | input | 2 | Index of the first useful slot in the quad-word |
| fetch_data | input | 128 | Four 32-bit instruction slots |
| fetch_ready | output | 1 | Buffer can accept a quad-word this cycle |
| line_valid | output | 1 | A complete instruction line is presented |
| line_data | output | 128 | Repacked line, first instruction in slot 0 |
| line_mask | output | 4 | Per-slot valid mask of the presented line |

## Verification
The assertions assume the fetch unit holds `fetch_offset` within 0..3. They also assume the fetch unit treats a quad-word as delivered only when ready was high in the same cycle. The stimulus respects both: offsets are always drawn from 0..3, and a reference queue in the bench counts a quad-word only when its own predicted ready is high. Flush is raised both at random and in directed cases, including while the buffer is full with a fetch pending. This covers the case where the discard has to win over a simultaneous write.

// File: rtl/iab_pkg.sv
package iab_pkg;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_FILL = 2'd1,
        S_FULL = 2'd2
    } iab_state_e;

    // modular increment of a ring index
    function automatic int unsigned ring_add(input int unsigned base,
                                             input int unsigned step,
                                             input int unsigned cap);
        return (base + step) % cap;
    endfunction

endpackage

// File: rtl/iab_realign.sv
module iab_realign #(
    parameter int SLOT_W = 32,
    parameter int SLOTS  = 4,
    parameter int OFF_W  = 2,
    parameter int CW     = 3
) (
    input  logic [SLOTS*SLOT_W-1:0]          quad_i,
    input  logic [OFF_W-1:0]                 offset_i,
    output logic [SLOTS-1:0][SLOT_W-1:0]     slots_o,
    output logic [CW-1:0]                    cnt_o
);

    // shift the useful slots down so the first kept slot lands at index 0
    always_comb begin
        for (int j = 0; j < SLOTS; j++) begin
            int src;
            src = j + int'(offset_i);
            if (src < SLOTS) begin
                slots_o[j] = quad_i[(src % SLOTS)*SLOT_W +: SLOT_W];
            end else begin
                slots_o[j] = '0;
            end
        end
        cnt_o = CW'(SLOTS - int'(offset_i));
    end

endmodule

// File: rtl/iab_slot_ram.sv
module iab_slot_ram
    import iab_pkg::*;
#(
    parameter int SLOT_W = 32,
    parameter int SLOTS  = 4,
    parameter int CAP    = 20,
    parameter int PTR_W  = 5,
    parameter int CW     = 3
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [PTR_W-1:0]                wr_ptr,
    input  logic [CW-1:0]                   wr_cnt,
    input  logic [SLOTS-1:0][SLOT_W-1:0]    wr_slots,
    input  logic [PTR_W-1:0]                rd_ptr,
    output logic [SLOTS-1:0][SLOT_W-1:0]    rd_win
);

    logic [SLOT_W-1:0] mem [CAP];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int j = 0; j < SLOTS; j++) begin
                if (CW'(j) < wr_cnt) begin
                    mem[PTR_W'(ring_add(32'(wr_ptr), j, CAP))] <= wr_slots[j];
                end
            end
        end
    end

    always_comb begin
        for (int j = 0; j < SLOTS; j++) begin
            rd_win[j] = mem[PTR_W'(ring_add(32'(rd_ptr), j, CAP))];
        end
    end

    // R3: a write always carries between one and SLOTS slots
    a_r3_write_count: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_cnt != '0) && (int'(wr_cnt) <= SLOTS));

endmodule

// File: rtl/iab_line_scan.sv
module iab_line_scan #(
    parameter int SLOT_W  = 32,
    parameter int SLOTS   = 4,
    parameter int EOL_BIT = 31,
    parameter int CNT_W   = 5,
    parameter int CW      = 3
) (
    input  logic [SLOTS-1:0][SLOT_W-1:0]    win_i,
    input  logic [CNT_W-1:0]                avail_i,
    output logic                            complete_o,
    output logic [CW-1:0]                   len_o,
    output logic [SLOTS-1:0]                mask_o,
    output logic [SLOTS-1:0][SLOT_W-1:0]    data_o
);

    logic found;

    always_comb begin
        found = 1'b0;
        len_o = CW'(SLOTS);
        for (int j = 0; j < SLOTS; j++) begin
            if (!found && (CNT_W'(j) < avail_i) && win_i[j][EOL_BIT]) begin
                found = 1'b1;
                len_o = CW'(j + 1);
            end
        end
        complete_o = found || (int'(avail_i) >= SLOTS);
        for (int j = 0; j < SLOTS; j++) begin
            mask_o[j] = (CW'(j) < len_o);
            data_o[j] = mask_o[j] ? win_i[j] : '0;
        end
    end

endmodule

// File: rtl/iab_ctrl.sv
module iab_ctrl
    import iab_pkg::*;
#(
    parameter int SLOTS = 4,
    parameter int CAP   = 20,
    parameter int CNT_W = 5,
    parameter int PTR_W = 5,
    parameter int CW    = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                flush,
    input  logic                fetch_valid,
    input  logic                line_complete,
    input  logic [CW-1:0]       push_cnt,
    input  logic [CW-1:0]       pop_cnt,
    output logic                fetch_ready,
    output logic                line_valid,
    output logic                push_en,
    output logic [PTR_W-1:0]    head,
    output logic [PTR_W-1:0]    tail,
    output logic [CNT_W-1:0]    count,
    output iab_state_e          state
);

    localparam int ROOM_LIMIT = CAP - SLOTS;

    iab_state_e         state_q, state_d;
    logic [CNT_W-1:0]   count_q, count_d, push_amt, pop_amt;
    logic [PTR_W-1:0]   head_q, head_d, tail_q, tail_d;

    // output process
    always_comb begin
        fetch_ready = (state_q != S_FULL) && !flush;
        push_en     = fetch_valid && fetch_ready;
        line_valid  = (state_q != S_IDLE) && line_complete && !flush;
    end

    always_comb begin
        push_amt = push_en    ? CNT_W'(push_cnt) : '0;
        pop_amt  = line_valid ? CNT_W'(pop_cnt)  : '0;
        if (flush) begin
            count_d = '0;
            head_d  = '0;
            tail_d  = '0;
        end else begin
            count_d = count_q - pop_amt + push_amt;
            head_d  = PTR_W'(ring_add(32'(head_q), 32'(pop_amt), CAP));
            tail_d  = PTR_W'(ring_add(32'(tail_q), 32'(push_amt), CAP));
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (count_d != '0) state_d = S_FILL;
            end
            S_FILL: begin
                if (count_d == '0)                    state_d = S_IDLE;
                else if (int'(count_d) > ROOM_LIMIT)  state_d = S_FULL;
            end
            S_FULL: begin
                if (count_d == '0)                    state_d = S_IDLE;
                else if (int'(count_d) <= ROOM_LIMIT) state_d = S_FILL;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
            head_q  <= '0;
            tail_q  <= '0;
        end else begin
            count_q <= count_d;
            head_q  <= head_d;
            tail_q  <= tail_d;
        end
    end

    assign head  = head_q;
    assign tail  = tail_q;
    assign count = count_q;
    assign state = state_q;

    // R9: occupancy bounded by the ring size
    a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        int'(count_q) <= CAP);

    // R2: full state blocks fetch
    a_r2_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FULL) |-> !fetch_ready);

    // R2: room for a quad-word keeps fetch open
    a_r2_room_open: assert property (@(posedge clk) disable iff (!rst_n)
        ((int'(count_q) <= ROOM_LIMIT) && !flush) |-> fetch_ready);

    // R7: flush leaves the ring empty
    a_r7_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count_q == '0) && (state_q == S_IDLE));

    // R5: nothing issues from an empty ring
    a_r5_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q == '0) |-> !line_valid);

endmodule

// File: rtl/iab_align_top.sv
module iab_align_top
    import iab_pkg::*;
#(
    parameter int SLOT_W  = 32,
    parameter int SLOTS   = 4,
    parameter int DEPTH_Q = 5,
    parameter int EOL_BIT = 31
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        flush,
    input  logic                        fetch_valid,
    input  logic [$clog2(SLOTS)-1:0]    fetch_offset,
    input  logic [SLOTS*SLOT_W-1:0]     fetch_data,
    output logic                        fetch_ready,
    output logic                        line_valid,
    output logic [SLOTS*SLOT_W-1:0]     line_data,
    output logic [SLOTS-1:0]            line_mask
);

    localparam int CAP   = DEPTH_Q * SLOTS;
    localparam int OFF_W = $clog2(SLOTS);
    localparam int CW    = $clog2(SLOTS + 1);
    localparam int CNT_W = $clog2(CAP + 1);
    localparam int PTR_W = $clog2(CAP);

    logic [SLOTS-1:0][SLOT_W-1:0] al_slots, rd_win, ln_data;
    logic [CW-1:0]                al_cnt, ln_len;
    logic                         ln_complete, push_en;
    logic [PTR_W-1:0]             head, tail;
    logic [CNT_W-1:0]             count;
    iab_state_e                   state;

    iab_realign #(.SLOT_W(SLOT_W), .SLOTS(SLOTS), .OFF_W(OFF_W), .CW(CW)) u_realign (
        .quad_i   (fetch_data),
        .offset_i (fetch_offset),
        .slots_o  (al_slots),
        .cnt_o    (al_cnt)
    );

    iab_slot_ram #(.SLOT_W(SLOT_W), .SLOTS(SLOTS), .CAP(CAP), .PTR_W(PTR_W), .CW(CW)) u_ram (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (push_en),
        .wr_ptr   (tail),
        .wr_cnt   (al_cnt),
        .wr_slots (al_slots),
        .rd_ptr   (head),
        .rd_win   (rd_win)
    );

    iab_line_scan #(.SLOT_W(SLOT_W), .SLOTS(SLOTS), .EOL_BIT(EOL_BIT), .CNT_W(CNT_W), .CW(CW)) u_scan (
        .win_i      (rd_win),
        .avail_i    (count),
        .complete_o (ln_complete),
        .len_o      (ln_len),
        .mask_o     (line_mask),
        .data_o     (ln_data)
    );

    iab_ctrl #(.SLOTS(SLOTS), .CAP(CAP), .CNT_W(CNT_W), .PTR_W(PTR_W), .CW(CW)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .flush         (flush),
        .fetch_valid   (fetch_valid),
        .line_complete (ln_complete),
        .push_cnt      (al_cnt),
        .pop_cnt       (ln_len),
        .fetch_ready   (fetch_ready),
        .line_valid    (line_valid),
        .push_en       (push_en),
        .head          (head),
        .tail          (tail),
        .count         (count),
        .state         (state)
    );

    assign line_data = ln_data;

    // R4: a presented mask is a contiguous run starting at slot 0
    a_r4_mask_shape: assert property (@(posedge clk) disable iff (!rst_n)
        line_valid |-> line_mask[0] && ((line_mask & (line_mask + 1'b1)) == '0));

    // R6: four buffered slots always form an issuable line
    a_r6_forced_line: assert property (@(posedge clk) disable iff (!rst_n)
        ((int'(count) >= SLOTS) && !flush) |-> line_valid);

    // R7: flush silences both handshakes
    a_r7_flush_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !line_valid && !fetch_ready);

endmodule

// File: tb/iab_align_top_tb_top.sv
module iab_align_top_tb_top;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         flush = 1'b0;
    logic         fetch_valid = 1'b0;
    logic [1:0]   fetch_offset = '0;
    logic [127:0] fetch_data = '0;
    logic         fetch_ready, line_valid;
    logic [127:0] line_data;
    logic [3:0]   line_mask;

    int checks = 0;
    int errors = 0;
    logic [31:0] mq[$];

    always #2 clk = ~clk;

    iab_align_top dut_i (
        .clk(clk), .rst_n(rst_n), .flush(flush), .fetch_valid(fetch_valid),
        .fetch_offset(fetch_offset), .fetch_data(fetch_data),
        .fetch_ready(fetch_ready), .line_valid(line_valid),
        .line_data(line_data), .line_mask(line_mask)
    );

    task automatic check(input bit ok, input string req,
                         input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] rslot(input int p_eol);
        logic [31:0] s;
        s = $urandom;
        s[31] = (($urandom % 100) < p_eol);
        return s;
    endfunction

    function automatic logic [127:0] rquad(input int p_eol);
        logic [127:0] q;
        for (int i = 0; i < 4; i++) q[i*32 +: 32] = rslot(p_eol);
        return q;
    endfunction

    function automatic logic [31:0] mk(input bit eol, input int tag);
        return {eol, 31'(tag)};
    endfunction

    // one cycle: drive, check against reference queue, advance the queue
    task automatic step(input bit v, input logic [127:0] d, input logic [1:0] off,
                        input bit fl, input string tag);
        int n, len;
        bit complete, exp_ready, exp_valid;
        logic [127:0] exp_data;
        logic [3:0] exp_mask;
        @(negedge clk);
        fetch_valid = v; fetch_data = d; fetch_offset = off; flush = fl;
        #1;
        n = mq.size();
        len = 0;
        for (int j = 0; j < 4 && j < n; j++)
            if (len == 0 && mq[j][31]) len = j + 1;
        complete = (len != 0) || (n >= 4);
        if (len == 0) len = 4;
        exp_ready = !fl && (20 - n >= 4);
        exp_valid = !fl && (n > 0) && complete;
        check(fetch_ready == exp_ready, fl ? "R7" : "R2 R9", 128'(fetch_ready), 128'(exp_ready));
        check(line_valid == exp_valid, fl ? "R7" : "R5", 128'(line_valid), 128'(exp_valid));
        if (exp_valid && line_valid) begin
            exp_data = '0;
            exp_mask = '0;
            for (int j = 0; j < len; j++) begin
                exp_data[j*32 +: 32] = mq[j];
                exp_mask[j] = 1'b1;
            end
            check(line_mask == exp_mask, "R4", 128'(line_mask), 128'(exp_mask));
            check(line_data == exp_data, tag, line_data, exp_data);
        end
        if (fl) begin
            mq.delete();
        end else begin
            if (exp_valid) for (int j = 0; j < len; j++) void'(mq.pop_front());
            if (v && exp_ready)
                for (int i = int'(off); i < 4; i++) mq.push_back(d[i*32 +: 32]);
        end
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        // R1: reset state
        repeat (3) @(negedge clk);
        #1;
        check(line_valid == 1'b0, "R1", 128'(line_valid), 128'(0));
        check(fetch_ready == 1'b1, "R1", 128'(fetch_ready), 128'(1));
        rst_n = 1'b1;

        // R8 / R5: line straddling two quad-words, with a gap cycle
        step(1'b1, {mk(0, 4), mk(0, 3), mk(1, 2), mk(0, 1)}, 2'd0, 1'b0, "R8");
        step(1'b0, '0, 2'd0, 1'b0, "R8");
        step(1'b0, '0, 2'd0, 1'b0, "R5");
        step(1'b1, {mk(1, 8), mk(0, 7), mk(1, 6), mk(1, 5)}, 2'd0, 1'b0, "R8");
        repeat (4) step(1'b0, '0, 2'd0, 1'b0, "R8");

        // R3: offset drops leading slots
        step(1'b1, {mk(1, 12), mk(0, 11), mk(1, 10), mk(1, 9)}, 2'd2, 1'b0, "R3");
        step(1'b1, {mk(0, 16), mk(1, 15), mk(1, 14), mk(1, 13)}, 2'd3, 1'b0, "R3");
        repeat (3) step(1'b0, '0, 2'd0, 1'b0, "R3");

        // R6: no end-of-line flag in four slots
        step(1'b1, {mk(0, 20), mk(0, 19), mk(0, 18), mk(0, 17)}, 2'd0, 1'b0, "R6");
        step(1'b1, {mk(0, 24), mk(0, 23), mk(1, 22), mk(0, 21)}, 2'd1, 1'b0, "R6");
        repeat (3) step(1'b0, '0, 2'd0, 1'b0, "R6");

        // R2 / R9: fill with one-instruction lines until fetch stalls
        repeat (12) step(1'b1, rquad(100), 2'd0, 1'b0, "R8");

        // R7: flush while full with fetch offered
        step(1'b1, rquad(50), 2'd0, 1'b1, "R7");
        step(1'b0, '0, 2'd0, 1'b0, "R7");
        step(1'b1, rquad(50), 2'd1, 1'b0, "R7");

        // mixed random traffic
        for (int k = 0; k < 3000; k++) begin
            bit v, fl;
            logic [1:0] off;
            v   = (($urandom % 100) < 75);
            fl  = (($urandom % 100) < 3);
            off = (($urandom % 4) == 0) ? 2'($urandom % 4) : 2'd0;
            step(v, rquad(int'($urandom % 70)), off, fl, "R8");
        end
        repeat (8) step(1'b0, '0, 2'd0, 1'b0, "R8");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule